// File: doc/BRIEF.md
# Pin Bank Controller with Edge Interrupts

The block controls a bank of 32 general-purpose pins through a small word-addressed register bus: an address, a write strobe, write data, and read data that follows the address in the same cycle. Each pin can be an input or an output. An output can push-pull or open-drain. Software reads and writes pin values through a single data register. The block drives an output-enable and an output value for each pad and samples each pad's input level through a two-stage synchronizer.

Input pins whose input buffer is switched on are watched for level changes. Each change that the pin's edge mode accepts sets a sticky event bit. Software clears an event bit by writing a one to it. One interrupt line is high whenever an event bit is set and that pin's mask bit is also set. It gives the interrupt controller a single summary of all pending, enabled pin events.

Top module: `pinbank_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, every pad output-enable is low, no event is pending and the interrupt line is low.
- R2: Registers sit at byte offsets 0x00 direction, 0x04 open-drain select, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge mode and 0x18 input-buffer enable. Pin n (pad index n) is controlled by register bit 31−n, so pin 0 is the most significant bit.
- R3: A direction bit of 1 makes the pin an output. With open-drain select 0 the pin drives its pad with output-enable high and output value equal to its data bit. A direction bit of 0 leaves output-enable low and output value low.
- R4: On an output pin with open-drain select 1, a data bit of 0 drives the pad low with output-enable high. A data bit of 1 releases the pad with output-enable low. The output value is always low.
- R5: A data read returns the written data bit for output pins and the synchronized pad level for input pins. A pad change shows up in the read value two clock edges after it is applied.
- R6: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R7: An edge-mode bit of 1 records only falling edges on that pin. A 0 records both rising and falling edges. The event bit is set on the third clock edge after the pad changes.
- R8: The interrupt line is high exactly while some bit is set in both the event and mask registers, and it follows those registers with no further delay.
- R9: While a pin's input-buffer enable bit is 0, its input level reads as 0 and it records no events. Switching the buffer on or off does not itself record an event.
- R10: Reads from any offset not listed in R2 return zero, and writes to such offsets change no register.
- R11: An edge that arrives in the same cycle as a write-one-to-clear of the same event bit leaves the event bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Pad input levels, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| pad_out | output | 32 | Pad output values, index = pin number |
| irq | output | 1 | Level interrupt: any event that is also unmasked |

## Verification
Register writes take effect on the clock edge that samples the strobe. Read data, pad controls and the interrupt line follow the registers without delay, so those are checked half a cycle after the write edge. A pad change is visible on data reads after two clock edges and raises its event and the interrupt on the third. The bench applies pad changes just after an edge and samples at the falling edge of the exact cycle where each result is due. It also samples one cycle earlier to confirm the result has not arrived yet. The same-cycle clear case places the clearing write in the cycle whose closing edge latches the edge.

// File: rtl/pinbank_pkg.sv
// Package: register selection shared by the pin bank controller.
// Assumes byte addressing with 32-bit registers on word boundaries.
package pinbank_pkg;

    localparam logic [7:0] OFF_DIR = 8'h00;
    localparam logic [7:0] OFF_ODS = 8'h04;
    localparam logic [7:0] OFF_DAT = 8'h08;
    localparam logic [7:0] OFF_EVT = 8'h0C;
    localparam logic [7:0] OFF_MSK = 8'h10;
    localparam logic [7:0] OFF_MOD = 8'h14;
    localparam logic [7:0] OFF_IBE = 8'h18;

    typedef enum logic [2:0] {
        SEL_DIR, SEL_ODS, SEL_DAT, SEL_EVT,
        SEL_MSK, SEL_MOD, SEL_IBE, SEL_NONE
    } sel_e;

    // Map a byte offset to the register it names; anything else is SEL_NONE.
    function automatic sel_e decode(input logic [7:0] a);
        case (a)
            OFF_DIR: return SEL_DIR;
            OFF_ODS: return SEL_ODS;
            OFF_DAT: return SEL_DAT;
            OFF_EVT: return SEL_EVT;
            OFF_MSK: return SEL_MSK;
            OFF_MOD: return SEL_MOD;
            OFF_IBE: return SEL_IBE;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent; no bus coherence is implied.
module pinbank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/pinbank_evt.sv
// Edge detector and sticky event register, one bit per pin.
// Assumes 'cur' is already synchronized. Compares against last cycle's
// raw level so that toggling the buffer enable produces no edge.
// A detected edge wins over a write-one-to-clear in the same cycle.
module pinbank_evt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] ibe,
    input  logic [W-1:0] fall_only,
    input  logic [W-1:0] clr,
    output logic [W-1:0] hit,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev;

    // Remember the previous synchronized level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    // Qualified edge: level changed, buffer on, and not a rise on a fall-only pin.
    always_comb begin
        hit = ibe & (cur ^ prev) & ~(fall_only & cur);
    end

    // Sticky events: cleared by written ones, set by edges with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= '0;
        else        evt <= (evt & ~clr) | hit;
    end

endmodule

// File: rtl/pinbank_regs.sv
// Control register file and read multiplexer for the pin bank.
// Assumes register bit order (bit W-1-n belongs to pin n); pad-order
// reversal is done by the caller. Read data is combinational.
module pinbank_regs #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  evt,
    input  logic [W-1:0]  smp,
    output logic [W-1:0]  dir,
    output logic [W-1:0]  ods,
    output logic [W-1:0]  dat,
    output logic [W-1:0]  msk,
    output logic [W-1:0]  fmode,
    output logic [W-1:0]  ibe,
    output logic [W-1:0]  clr,
    output logic [W-1:0]  rdata
);
    import pinbank_pkg::*;

    sel_e sel;

    // Decode the offset once for both write and read paths.
    always_comb begin
        sel = decode(8'(addr));
    end

    // Write the addressed control register; undefined offsets fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir   <= '0;
            ods   <= '0;
            dat   <= '0;
            msk   <= '0;
            fmode <= '0;
            ibe   <= '0;
        end else if (we) begin
            case (sel)
                SEL_DIR: dir   <= wdata;
                SEL_ODS: ods   <= wdata;
                SEL_DAT: dat   <= wdata;
                SEL_MSK: msk   <= wdata;
                SEL_MOD: fmode <= wdata;
                SEL_IBE: ibe   <= wdata;
                default: ;
            endcase
        end
    end

    // Write-one-to-clear vector handed to the event register.
    always_comb begin
        clr = (we && sel == SEL_EVT) ? wdata : '0;
    end

    // Read multiplexer; data merges output latches with sampled inputs.
    always_comb begin
        case (sel)
            SEL_DIR: rdata = dir;
            SEL_ODS: rdata = ods;
            SEL_DAT: rdata = (dir & dat) | (~dir & smp);
            SEL_EVT: rdata = evt;
            SEL_MSK: rdata = msk;
            SEL_MOD: rdata = fmode;
            SEL_IBE: rdata = ibe;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinbank_ctrl.sv
// Top of the pin bank controller: registers, synchronizer, edge events,
// pad drive and interrupt summary. Pad vectors are indexed by pin number;
// registers are stored with pin n at bit NPINS-1-n.
module pinbank_ctrl #(
    parameter int NPINS  = 32,
    parameter int AW     = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic             irq
);

    localparam int TOP = NPINS - 1;

    logic [NPINS-1:0] in_bits, raw, smp;
    logic [NPINS-1:0] dir_q, ods_q, dat_q, msk_q, mode_q, ibe_q, clr_v;
    logic [NPINS-1:0] evt_q, hit_v, oe_bits, out_bits;

    // Reverse pad order into register order and back.
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        assign in_bits[TOP-n] = pad_in[n];
        assign pad_oe[n]      = oe_bits[TOP-n];
        assign pad_out[n]     = out_bits[TOP-n];
    end

    pinbank_sync #(.W(NPINS), .STAGES(STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .din (in_bits), .dout (raw)
    );

    pinbank_evt #(.W(NPINS)) u_evt (
        .clk (clk), .rst_n (rst_n), .cur (raw), .ibe (ibe_q),
        .fall_only (mode_q), .clr (clr_v), .hit (hit_v), .evt (evt_q)
    );

    pinbank_regs #(.W(NPINS), .AW(AW)) u_regs (
        .clk (clk), .rst_n (rst_n), .we (bus_we), .addr (bus_addr),
        .wdata (bus_wdata), .evt (evt_q), .smp (smp),
        .dir (dir_q), .ods (ods_q), .dat (dat_q), .msk (msk_q),
        .fmode (mode_q), .ibe (ibe_q), .clr (clr_v), .rdata (bus_rdata)
    );

    // Pad drive: push-pull follows data; open-drain drives only lows.
    always_comb begin
        smp      = raw & ibe_q;
        oe_bits  = dir_q & ~(ods_q & dat_q);
        out_bits = dir_q & ~ods_q & dat_q;
    end

    // Interrupt summary of unmasked pending events.
    always_comb begin
        irq = |(evt_q & msk_q);
    end

endmodule

// File: rtl/pinbank_ctrl_chk.sv
// Checker for pinbank_ctrl, bound to every instance of it.
// Observes pads, bus and internal register/event state.
module pinbank_ctrl_chk #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          we,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  wdata,
    input logic [W-1:0]  pad_oe,
    input logic          irq,
    input logic [W-1:0]  evt,
    input logic [W-1:0]  hit,
    input logic [W-1:0]  cur,
    input logic [W-1:0]  fmode,
    input logic [W-1:0]  ibe,
    input logic [W-1:0]  dir,
    input logic [W-1:0]  msk
);
    import pinbank_pkg::*;

    logic evt_wr, undef_wr;
    always_comb begin
        evt_wr   = we && (decode(8'(addr)) == SEL_EVT);
        undef_wr = we && (decode(8'(addr)) == SEL_NONE);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && !irq && evt == '0));

    p_clear_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> ((evt & $past(wdata & ~hit)) == '0));

    p_clear_zero_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> ((evt & $past(evt & ~wdata)) == $past(evt & ~wdata)));

    p_no_rise_on_fall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & fmode & cur) == '0);

    p_buffer_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~ibe) == '0);

    p_undef_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        undef_wr |=> ($stable(dir) && $stable(msk) && $stable(fmode) && $stable(ibe)));

    p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((evt & $past(hit)) == $past(hit)));

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.W(NPINS), .AW(AW)) u_chk (
    .clk (clk), .rst_n (rst_n), .we (bus_we), .addr (bus_addr),
    .wdata (bus_wdata), .pad_oe (pad_oe), .irq (irq), .evt (evt_q),
    .hit (hit_v), .cur (raw), .fmode (mode_q), .ibe (ibe_q),
    .dir (dir_q), .msk (msk_q)
);

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/100ps
module pinbank_ctrl_tb;

    localparam logic [4:0] A_DIR = 5'h00, A_ODS = 5'h04, A_DAT = 5'h08,
                           A_EVT = 5'h0C, A_MSK = 5'h10, A_MOD = 5'h14,
                           A_IBE = 5'h18, A_BAD = 5'h1C, A_MIS = 5'h02;

    logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, pad_in = '0;
    logic [31:0] bus_rdata, pad_oe, pad_out;
    logic        irq;

    always #2.5 clk = ~clk;

    pinbank_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pad_in (pad_in),
        .pad_oe (pad_oe), .pad_out (pad_out), .irq (irq)
    );

    typedef enum int {K_RD, K_OE, K_OUT, K_IRQ} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    n_run = 0, n_fail = 0;
    bit    done = 0;

    // Monitor: at each falling edge, compare every pending expectation.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_OE:    act = pad_oe;
                K_OUT:   act = pad_out;
                default: act = {31'd0, irq};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] pb(input int p);
        return 32'h1 << (31 - p);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_we = 1'b0;
    endtask

    // Driver: present a read address, queue its expectation, one cycle.
    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        sbq.push_back('{kind: K_RD, exp: e, tag: tag});
        tick(1);
    endtask

    // Driver: queue a pad/irq expectation for the coming falling edge.
    task automatic port(input kind_t k, input logic [31:0] e, input string tag);
        sbq.push_back('{kind: k, exp: e, tag: tag});
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rd(A_DIR, 0, "R1 dir"); rd(A_ODS, 0, "R1 ods"); rd(A_DAT, 0, "R1 data");
        rd(A_EVT, 0, "R1 evt"); rd(A_MSK, 0, "R1 mask"); rd(A_MOD, 0, "R1 mode");
        port(K_OE, 0, "R1 oe"); port(K_IRQ, 0, "R1 irq");
        rd(A_IBE, 0, "R1 ibe");

        // R10: undefined offsets
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_BAD, 0, "R10 read undefined");
        wr(A_MIS, 32'hFFFF_FFFF);
        rd(A_DIR, 0, "R10 dir untouched");
        rd(A_MSK, 0, "R10 mask untouched");
        rd(A_IBE, 0, "R10 ibe untouched");

        // R3/R2: push-pull outputs on pins 0 and 5
        wr(A_DIR, pb(0) | pb(5));
        wr(A_DAT, pb(0));
        port(K_OE, 32'h0000_0021, "R3 oe");
        port(K_OUT, 32'h0000_0001, "R2 pin0 out");
        rd(A_DAT, pb(0), "R5 output latch readback");
        wr(A_DAT, pb(5));
        port(K_OUT, 32'h0000_0020, "R2 pin5 out");
        tick(1);

        // R4: open-drain on pin 5
        wr(A_ODS, pb(5));
        port(K_OE, 32'h0000_0001, "R4 released");
        port(K_OUT, 32'h0, "R4 released out");
        tick(1);
        wr(A_DAT, 32'h0);
        port(K_OE, 32'h0000_0021, "R4 drive low");
        port(K_OUT, 32'h0, "R4 low out");
        tick(1);
        wr(A_ODS, 0);
        wr(A_DIR, 0);
        port(K_OE, 32'h0, "R3 inputs");
        tick(1);

        // R9: buffer off, pin 9 toggles
        pad_in[9] = 1'b1;
        tick(4);
        rd(A_DAT, 0, "R9 reads zero");
        rd(A_EVT, 0, "R9 no event");
        pad_in[9] = 1'b0;
        tick(4);

        wr(A_IBE, 32'hFFFF_FFFF);
        rd(A_IBE, 32'hFFFF_FFFF, "R2 ibe readback");
        pad_in[9] = 1'b1;
        wr(A_IBE, 32'h0);
        wr(A_IBE, 32'hFFFF_FFFF);
        tick(4);
        rd(A_EVT, pb(9), "R9 enabled pin records");
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_IBE, 32'h0);
        pad_in[9] = 1'b0;
        tick(4);
        wr(A_IBE, 32'hFFFF_FFFF);
        tick(4);
        rd(A_EVT, 0, "R9 buffer toggle no event");

        wr(A_MSK, pb(12));

        // R5/R7: timing of a rising edge on pin 12, both-edge mode
        pad_in[12] = 1'b1;
        tick(1);
        rd(A_DAT, 0, "R5 not yet after one edge");
        port(K_IRQ, 0, "R7 no irq after two edges");
        rd(A_DAT, pb(12), "R5 input after two edges");
        port(K_IRQ, 1, "R8 irq after three edges");
        rd(A_EVT, pb(12), "R7 rise recorded");

        // R6: write-one-to-clear
        wr(A_EVT, 0);
        rd(A_EVT, pb(12), "R6 zero keeps");
        wr(A_EVT, ~pb(12));
        rd(A_EVT, pb(12), "R6 other bits keep");
        wr(A_EVT, pb(12));
        port(K_IRQ, 0, "R8 irq drops");
        rd(A_EVT, 0, "R6 one clears");

        // R7: falling edge in both-edge mode
        pad_in[12] = 1'b0;
        tick(4);
        rd(A_EVT, pb(12), "R7 fall recorded");
        wr(A_EVT, 32'hFFFF_FFFF);

        // R7: falling-only mode
        wr(A_MOD, pb(12));
        pad_in[12] = 1'b1;
        tick(4);
        rd(A_EVT, 0, "R7 rise ignored");
        pad_in[12] = 1'b0;
        tick(4);
        rd(A_EVT, pb(12), "R7 fall-only fall");
        wr(A_EVT, 32'hFFFF_FFFF);

        // R8: masking
        pad_in[20] = 1'b1;
        tick(4);
        port(K_IRQ, 0, "R8 masked event");
        rd(A_EVT, pb(20), "R8 event pending");
        wr(A_MSK, pb(12) | pb(20));
        port(K_IRQ, 1, "R8 unmask raises");
        tick(1);
        wr(A_EVT, pb(20));
        port(K_IRQ, 0, "R8 clear lowers");
        tick(1);

        // R11: falling edge meets a clear in the same cycle
        pad_in[20] = 1'b0;
        tick(2);
        wr(A_EVT, pb(20));
        port(K_IRQ, 1, "R11 irq stays");
        rd(A_EVT, pb(20), "R11 edge wins");
        wr(A_EVT, pb(20));
        rd(A_EVT, 0, "R11 later clear");

        tick(2);
        done = 1;
        summary();
        $finish;
    end

endmodule